// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block keeps an SDRAM refreshed and moves it in and out of its low-power states. While the memory is in normal operation, a down-counter raises a periodic refresh request to the command scheduler every programmed number of clock cycles. Software can also ask for self-refresh or power-down through two level-sensitive enables. The sequencer then produces the matching one-cycle command requests and waits for the scheduler's grant on each one.

Self-refresh is bracketed by refresh bursts. Before entry, the sequencer issues either a single refresh or one refresh for every row, depending on a pre-entry option. After exit, it does the same under a separate post-exit option. A status flag is high while the memory sits in self-refresh, but only when the pre-entry option asked for the full burst. The periodic counter is frozen while the memory is in self-refresh or power-down, and in the bursts around them. It restarts from the programmed interval when normal operation resumes.

Top module: `sdram_refresh_seq`

## Requirements
- R1: A write through `ivl_we`/`ivl_wdata` sets the periodic interval. In steady normal operation with prompt grants, consecutive periodic refresh grants are exactly that many cycles apart.
- R2: After reset the interval is 195 cycles, so the first two periodic refresh grants are 195 cycles apart.
- R3: Every command request stays high, with the same command, until it sees `grant` high in the same cycle. It is low in the following cycle. All requests are low after reset.
- R4: At most one of the five request outputs is high in any cycle.
- R5: When `sr_en` rises, the sequencer issues refresh requests and then a self-refresh entry request. There is one refresh when `full_before` is 0 and ROWS refreshes when it is 1, each separately granted.
- R6: When `sr_en` falls in self-refresh, the sequencer issues a self-refresh exit request and then refresh requests. There is one refresh when `full_after` is 0 and ROWS refreshes when it is 1. After that no further request comes until the next periodic one.
- R7: `sr_flag` is 1 from the grant of the entry request until the grant of the exit request, and only if `full_before` was 1 when entry began. Otherwise it is 0.
- R8: No refresh request is made while the memory is in self-refresh or power-down. After the exit sequence, the first periodic refresh grant follows the last exit grant by between the interval and the interval plus 3 cycles.
- R9: When `sr_en` and `pd_en` are both high in normal operation, self-refresh is entered and power-down is not. Power-down entry is requested only from normal operation, after any refresh burst has finished.
- R10: With `pd_en` high in normal operation and no refresh due, a power-down entry request is made. Once that is granted, clearing `pd_en` produces a power-down exit request.
- R11: A periodic refresh that comes due while a request is waiting for its grant is kept. It is requested in the second cycle after that grant, and at most one such refresh is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_en | input | 1 | Level request for self-refresh; clearing it requests exit |
| pd_en | input | 1 | Level request for power-down |
| full_before | input | 1 | 1: refresh all rows before self-refresh entry; 0: one refresh |
| full_after | input | 1 | 1: refresh all rows after self-refresh exit; 0: one refresh |
| ivl_we | input | 1 | Write strobe for the refresh interval |
| ivl_wdata | input | IVL_W | New refresh interval in cycles |
| grant | input | 1 | Scheduler accepts the request that is high in this cycle |
| req_ref | output | 1 | Auto-refresh command request |
| req_sr_enter | output | 1 | Self-refresh entry command request |
| req_sr_exit | output | 1 | Self-refresh exit command request |
| req_pd_enter | output | 1 | Power-down entry command request |
| req_pd_exit | output | 1 | Power-down exit command request |
| sr_flag | output | 1 | Memory is in self-refresh (entered with full pre-entry burst) |

## Verification
A wrong burst counter shows up at the ports as the wrong number of refresh grants between two low-power commands, and the bench sees it as soon as the entry or exit command appears. A corrupted or stale interval counter shows as a grant spacing that is off by one or more cycles within one interval period. A dropped pending refresh shows up two cycles after a delayed grant as a missing request. A state stuck in a low-power mode shows as a missing exit command within a few cycles of the enable being cleared.

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq #(
  parameter int IVL_W = 16,
  parameter int ROWS = 4096,
  parameter logic [IVL_W-1:0] IVL_RESET = 16'd195
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sr_en,
  input  logic             pd_en,
  input  logic             full_before,
  input  logic             full_after,
  input  logic             ivl_we,
  input  logic [IVL_W-1:0] ivl_wdata,
  input  logic             grant,
  output logic             req_ref,
  output logic             req_sr_enter,
  output logic             req_sr_exit,
  output logic             req_pd_enter,
  output logic             req_pd_exit,
  output logic             sr_flag
);
  localparam int ROW_W = $clog2(ROWS + 1);

  typedef enum logic [3:0] {
    S_RUN, S_PRE, S_SRE, S_SELF, S_SRX, S_POST, S_PDE, S_PWRDN, S_PDX
  } st_t;
  typedef enum logic [2:0] {K_REF, K_SRE, K_SRX, K_PDE, K_PDX} kind_t;

  st_t              st;
  kind_t            kind;
  logic             req, pend, full_b_l;
  logic [IVL_W-1:0] ivl, cnt;
  logic [ROW_W-1:0] left;

  wire take = req && grant;
  wire due  = (st == S_RUN) && (cnt <= IVL_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_RUN;
      kind     <= K_REF;
      req      <= 1'b0;
      pend     <= 1'b0;
      full_b_l <= 1'b0;
      ivl      <= IVL_RESET;
      cnt      <= IVL_RESET;
      left     <= '0;
      sr_flag  <= 1'b0;
    end else begin
      if (ivl_we) ivl <= ivl_wdata;
      if (take) req <= 1'b0;
      if (st == S_RUN) begin
        if (due) begin
          cnt  <= ivl;
          pend <= 1'b1;
        end else begin
          cnt <= cnt - IVL_W'(1);
        end
      end
      case (st)
        S_RUN: if (!req) begin
          if (sr_en) begin
            st       <= S_PRE;
            left     <= full_before ? ROW_W'(ROWS) : ROW_W'(1);
            full_b_l <= full_before;
            pend     <= 1'b0;
          end else if (pend) begin
            req  <= 1'b1;
            kind <= K_REF;
            pend <= due;
          end else if (pd_en && !due) begin
            req  <= 1'b1;
            kind <= K_PDE;
            st   <= S_PDE;
          end
        end
        S_PRE: begin
          if (take) begin
            left <= left - ROW_W'(1);
            if (left == ROW_W'(1)) st <= S_SRE;
          end else if (!req) begin
            req  <= 1'b1;
            kind <= K_REF;
          end
        end
        S_SRE: begin
          if (take) begin
            st      <= S_SELF;
            sr_flag <= full_b_l;
          end else if (!req) begin
            req  <= 1'b1;
            kind <= K_SRE;
          end
        end
        S_SELF: if (!sr_en) st <= S_SRX;
        S_SRX: begin
          if (take) begin
            st      <= S_POST;
            left    <= full_after ? ROW_W'(ROWS) : ROW_W'(1);
            sr_flag <= 1'b0;
          end else if (!req) begin
            req  <= 1'b1;
            kind <= K_SRX;
          end
        end
        S_POST: begin
          if (take) begin
            left <= left - ROW_W'(1);
            if (left == ROW_W'(1)) begin
              st   <= S_RUN;
              cnt  <= ivl;
              pend <= 1'b0;
            end
          end else if (!req) begin
            req  <= 1'b1;
            kind <= K_REF;
          end
        end
        S_PDE: if (take) st <= S_PWRDN;
        S_PWRDN: if (!pd_en || sr_en) st <= S_PDX;
        S_PDX: begin
          if (take) begin
            st   <= S_RUN;
            cnt  <= ivl;
            pend <= 1'b0;
          end else if (!req) begin
            req  <= 1'b1;
            kind <= K_PDX;
          end
        end
        default: st <= S_RUN;
      endcase
    end
  end

  assign req_ref      = req && (kind == K_REF);
  assign req_sr_enter = req && (kind == K_SRE);
  assign req_sr_exit  = req && (kind == K_SRX);
  assign req_pd_enter = req && (kind == K_PDE);
  assign req_pd_exit  = req && (kind == K_PDX);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !grant) |=> (req && $stable(kind)));
  p_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !req);
  p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ref, req_sr_enter, req_sr_exit, req_pd_enter, req_pd_exit}));
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SELF || st == S_PWRDN) |-> !req_ref);
  p_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sr_flag |-> (st == S_SELF || st == S_SRX));
  p_pend_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && pend && !req && !sr_en) |=> req_ref);
  p_pd_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_pd_enter) |-> (!$past(sr_en) && $past(st) == S_RUN));
endmodule

// File: tb/sdram_refresh_seq_test.sv
`timescale 1ns/1ps
module sdram_refresh_seq_test;
  localparam int ROWS = 6;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sr_en = 0, pd_en = 0, fb = 0, fa = 0, ivl_we = 0;
  logic [15:0] ivl_wdata = '0;
  logic auto_g = 0, man_g = 0, g_auto = 0;
  wire grant;
  wire r_ref, r_sre, r_srx, r_pde, r_pdx, sr_flag;
  int errors = 0, checks = 0, cyc = 0, idx = 0;
  int log_k[256];
  int log_t[256];

  always #4 clk = ~clk;

  sdram_refresh_seq #(.ROWS(ROWS)) uut (
    .clk(clk), .rst_n(rst_n), .sr_en(sr_en), .pd_en(pd_en),
    .full_before(fb), .full_after(fa), .ivl_we(ivl_we), .ivl_wdata(ivl_wdata),
    .grant(grant), .req_ref(r_ref), .req_sr_enter(r_sre), .req_sr_exit(r_srx),
    .req_pd_enter(r_pde), .req_pd_exit(r_pdx), .sr_flag(sr_flag));

  wire any = r_ref | r_sre | r_srx | r_pde | r_pdx;
  assign grant = auto_g ? g_auto : man_g;
  always @(negedge clk) g_auto <= any;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst_n && grant && any) begin
      log_k[idx % 256] <= r_ref ? 1 : r_sre ? 2 : r_srx ? 3 : r_pde ? 4 : 5;
      log_t[idx % 256] <= cyc;
      idx <= idx + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int k_at(int p); return log_k[p % 256]; endfunction
  function automatic int t_at(int p); return log_t[p % 256]; endfunction

  task automatic wait_log(input int target, input int maxc, input string tag);
    int c = 0;
    while (idx < target && c < maxc) begin @(negedge clk); c++; end
    chk(idx >= target, tag, idx, target);
  endtask

  task automatic set_ivl(input int v);
    @(negedge clk); ivl_wdata = 16'(v); ivl_we = 1;
    @(negedge clk); ivl_we = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!any, "R3 requests low after reset", int'(any), 0);
    chk(!sr_flag, "R7 flag low after reset", int'(sr_flag), 0);
  endtask

  task automatic t_default_interval;
    int b;
    auto_g = 1; b = idx;
    wait_log(b + 2, 600, "R2 two periodic refreshes");
    chk(t_at(b + 1) - t_at(b) == 195, "R2 reset interval", t_at(b + 1) - t_at(b), 195);
  endtask

  task automatic t_interval;
    int b;
    set_ivl(20); b = idx;
    wait_log(b + 3, 400, "R1 refreshes after write");
    chk(t_at(b + 2) - t_at(b + 1) == 20, "R1 programmed interval", t_at(b + 2) - t_at(b + 1), 20);
    chk(k_at(b + 2) == 1, "R1 periodic kind", k_at(b + 2), 1);
  endtask

  task automatic t_pending;
    int c = 0;
    @(negedge clk); auto_g = 0; man_g = 0;
    while (!r_ref && c < 100) begin @(negedge clk); c++; end
    chk(r_ref, "R3 request raised", int'(r_ref), 1);
    repeat (45) @(negedge clk);
    chk(r_ref, "R3 request held without grant", int'(r_ref), 1);
    man_g = 1; @(negedge clk); man_g = 0;
    chk(!r_ref, "R3 request dropped after grant", int'(r_ref), 0);
    @(negedge clk);
    chk(r_ref, "R11 pending refresh kept", int'(r_ref), 1);
    auto_g = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_powerdown;
    int b, c = 0;
    pd_en = 1; b = idx;
    while (!(idx > b && k_at(idx - 1) == 4) && c < 200) begin @(negedge clk); c++; end
    chk(idx > b && k_at(idx - 1) == 4, "R10 power-down entry", k_at(idx - 1), 4);
    b = idx;
    repeat (300) @(negedge clk);
    chk(idx == b, "R8 no refresh in power-down", idx - b, 0);
    pd_en = 0;
    wait_log(b + 2, 200, "R10 exit then refresh");
    chk(k_at(b) == 5, "R10 power-down exit", k_at(b), 5);
    chk(k_at(b + 1) == 1 && t_at(b + 1) - t_at(b) >= 20 && t_at(b + 1) - t_at(b) <= 23,
        "R8 counter restarts after exit", t_at(b + 1) - t_at(b), 20);
  endtask

  task automatic t_sr_single;
    int b;
    fb = 0; fa = 0; @(negedge clk); sr_en = 1; b = idx;
    wait_log(b + 2, 200, "R5 single entry sequence");
    chk(k_at(b) == 1 && k_at(b + 1) == 2, "R5 one refresh then entry", k_at(b) * 10 + k_at(b + 1), 12);
    repeat (2) @(negedge clk);
    chk(!sr_flag, "R7 flag zero without full burst", int'(sr_flag), 0);
    repeat (200) @(negedge clk);
    chk(idx == b + 2, "R8 no refresh in self-refresh", idx - b, 2);
    sr_en = 0;
    wait_log(b + 4, 200, "R6 single exit sequence");
    chk(k_at(b + 2) == 3 && k_at(b + 3) == 1, "R6 exit then one refresh", k_at(b + 2) * 10 + k_at(b + 3), 31);
    repeat (20) @(negedge clk);
    chk(idx == b + 4, "R6 nothing after single burst", idx - b, 4);
  endtask

  task automatic t_sr_full;
    int b, n = 0;
    fb = 1; fa = 1; @(negedge clk); sr_en = 1; b = idx;
    wait_log(b + ROWS + 1, 500, "R5 full entry sequence");
    for (int i = 0; i < ROWS; i++) if (k_at(b + i) == 1) n++;
    chk(n == ROWS && k_at(b + ROWS) == 2, "R5 all rows then entry", n, ROWS);
    repeat (2) @(negedge clk);
    chk(sr_flag, "R7 flag set after full burst", int'(sr_flag), 1);
    sr_en = 0; n = 0;
    wait_log(b + 2 * ROWS + 2, 500, "R6 full exit sequence");
    for (int i = 0; i < ROWS; i++) if (k_at(b + ROWS + 2 + i) == 1) n++;
    chk(k_at(b + ROWS + 1) == 3 && n == ROWS, "R6 exit then all rows", n, ROWS);
    chk(!sr_flag, "R7 flag cleared after exit", int'(sr_flag), 0);
    repeat (20) @(negedge clk);
    chk(idx == b + 2 * ROWS + 2, "R6 burst length exact", idx - b, 2 * ROWS + 2);
    fb = 0; fa = 0;
  endtask

  task automatic t_priority;
    int b;
    @(negedge clk); sr_en = 1; pd_en = 1; b = idx;
    wait_log(b + 2, 200, "R9 entry with both enables");
    chk(k_at(b) == 1 && k_at(b + 1) == 2, "R9 self-refresh wins", k_at(b) * 10 + k_at(b + 1), 12);
    repeat (10) @(negedge clk);
    sr_en = 0;
    wait_log(b + 5, 200, "R9 exit then power-down");
    chk(k_at(b + 2) == 3 && k_at(b + 3) == 1 && k_at(b + 4) == 4, "R9 power-down after burst",
        k_at(b + 2) * 100 + k_at(b + 3) * 10 + k_at(b + 4), 314);
    pd_en = 0;
    wait_log(b + 6, 200, "R10 exit after priority");
    chk(k_at(b + 5) == 5, "R10 power-down exit", k_at(b + 5), 5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_default_interval();
    t_interval();
    t_pending();
    t_powerdown();
    set_ivl(60000);
    repeat (40) @(negedge clk);
    t_sr_single();
    t_sr_full();
    t_priority();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule